// File: doc/BRIEF.md
# Dual-Mode Register Access Port

This block lets a host reach a small on-chip register file over one of two pin-level protocols that share the same three control pins. When reset is released, the level on the enable/strobe pin selects the protocol, and that choice holds until the next reset. In the serial protocol the host sends 16-bit command frames on a data pin, clocked by a serial clock, and closes each frame with a high pulse on the enable pin. Read-back data comes out on a separate data-out pin. In the parallel protocol the host uses an active-low strobe, an address/data select and a read/write select to move bytes over an 8-bit bus. A write takes one strobe to load the address and a second to write the data.

All pin inputs pass through synchronizers into the system clock domain. Toward the register file the block drives single-cycle write and read requests, each with an address and write data. Read data is returned combinationally in the cycle of the read request. The pads are modelled as separate input, output and output-enable signals, and an active-low output-enable pin can silence every output driver.

Top module: `dual_mode_reg_if`

## Requirements
- R1: While reset is asserted, and until the interface type has been captured, no write or read request is issued and neither the bus nor the data-out pin is driven.
- R2: The level on `sen_stb_i` at the first clock edge after reset release selects the interface: 0 gives serial, 1 gives parallel. The selection stays fixed until the next reset.
- R3: Serial frame: 16 bits, most significant first, each sampled on a rising edge of `sck_rnw_i`. The frame holds bit 15 = read flag (0 = write), bits 14:9 = address, bit 8 = spare, bits 7:0 = data. A write frame issues one write request, carrying that address and data, when `sen_stb_i` rises.
- R4: A serial frame closed after fewer or more than exactly 16 clock edges issues no request.
- R5: A serial read frame issues a read request at the enable rise. The 8 read-back bits then appear on `sdo_o`, most significant first. Each bit is valid before a rising serial clock edge, and the next rising edge advances to the next bit. `sdo_oe_o` is high for exactly those 8 bits.
- R6: Parallel mode: a strobe (`sen_stb_i` low) with `sck_rnw_i`=0 and `sdi_dna_i`=0 loads `bus_i[5:0]` as the address. A strobe with `sck_rnw_i`=0 and `sdi_dna_i`=1 writes `bus_i` to the last loaded address, and any number of data strobes may reuse that address.
- R7: Parallel mode: while the strobe is low with `sck_rnw_i`=1, `bus_oe_o` is high and `bus_o` carries the register at the last loaded address. `bus_oe_o` drops after the strobe returns high.
- R8: With `oe_ni`=1, neither `bus_oe_o` nor `sdo_oe_o` is asserted.
- R9: Serial mode never drives the bus, and a strobe-like pulse on the shared pins writes nothing. Parallel mode never drives `sdo_oe_o`.
- R10: Write and read requests are single-cycle pulses and are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sen_stb_i | input | 1 | Serial enable (active high) / parallel strobe (active low); level at reset release picks the mode |
| sck_rnw_i | input | 1 | Serial clock / parallel read-not-write |
| sdi_dna_i | input | 1 | Serial data in / parallel data-not-address |
| oe_ni | input | 1 | Active-low output enable for all drivers |
| bus_i | input | 8 | Parallel bus, pad input side |
| bus_o | output | 8 | Parallel bus read-back data |
| bus_oe_o | output | 1 | Parallel bus output enable |
| sdo_o | output | 1 | Serial read-back data |
| sdo_oe_o | output | 1 | Serial read-back output enable |
| reg_we_o | output | 1 | Register write request |
| reg_re_o | output | 1 | Register read request |
| reg_addr_o | output | 6 | Register address |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register read data, valid in the read-request cycle |

## Verification
The bench writes and reads back every one of the 64 addresses in each mode, using a distinct arithmetic data pattern per mode. A design that mis-ordered the frame fields or the read-back bits would put the wrong value into the bench's register model. Frames one edge short and one edge long are sent, and a counter that committed on at least 16 edges instead of exactly 16 would corrupt an address. A parallel data strobe with no new address must land at the old address, which catches a design that clears its address after each write. Reads with the output enable withdrawn, and strobe pulses sent in serial mode, show whether a driver leaks onto a pin it does not own.

// File: rtl/rif_pkg.sv
package rif_pkg;
  localparam int RIF_ADDR_W = 6;
  localparam int RIF_DATA_W = 8;
  localparam int PIN_CS = 0;
  localparam int PIN_CK = 1;
  localparam int PIN_DI = 2;
  localparam int PIN_N  = 3;

  typedef enum logic {
    MODE_SER = 1'b0,
    MODE_PAR = 1'b1
  } if_mode_e;
endpackage

// File: rtl/rif_pin_sync.sv
module rif_pin_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rif_ser_ctrl.sv
module rif_ser_ctrl #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cs_rise_i,
  input  logic              ck_rise_i,
  input  logic              sdi_i,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              cmd_we_o,
  output logic              cmd_re_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_wdata_o,
  output logic              sdo_o,
  output logic              busy_o
);
  localparam int FRAME_W = ADDR_W + DATA_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int OB_W    = $clog2(DATA_W);

  logic [FRAME_W-1:0] shin_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [DATA_W-1:0]  shout_q;
  logic [OB_W-1:0]    obit_q;
  logic               rd_act_q;
  logic               frame_ok;
  logic               frame_rd;

  assign frame_rd    = shin_q[FRAME_W-1];
  assign frame_ok    = en_i && cs_rise_i && (cnt_q == CNT_W'(FRAME_W));
  assign cmd_we_o    = frame_ok && !frame_rd;
  assign cmd_re_o    = frame_ok && frame_rd;
  assign cmd_addr_o  = shin_q[FRAME_W-2 -: ADDR_W];
  assign cmd_wdata_o = shin_q[DATA_W-1:0];
  assign sdo_o       = rd_act_q && shout_q[DATA_W-1];
  assign busy_o      = rd_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shin_q   <= '0;
      cnt_q    <= '0;
      shout_q  <= '0;
      obit_q   <= '0;
      rd_act_q <= 1'b0;
    end else if (!en_i) begin
      shin_q   <= '0;
      cnt_q    <= '0;
      shout_q  <= '0;
      obit_q   <= '0;
      rd_act_q <= 1'b0;
    end else begin
      if (cs_rise_i) begin
        cnt_q    <= '0;
        obit_q   <= '0;
        rd_act_q <= frame_ok && frame_rd;
      end else if (ck_rise_i) begin
        if (rd_act_q) begin
          shout_q <= {shout_q[DATA_W-2:0], 1'b0};
          obit_q  <= obit_q + 1'b1;
          if (obit_q == OB_W'(DATA_W-1)) rd_act_q <= 1'b0;
        end else begin
          shin_q <= {shin_q[FRAME_W-2:0], sdi_i};
          // saturate one past a full frame so over-long frames are rejected
          if (cnt_q != CNT_W'(FRAME_W+1)) cnt_q <= cnt_q + 1'b1;
        end
      end
      if (ld_i) shout_q <= rdata_i;
    end
  end
endmodule

// File: rtl/rif_par_ctrl.sv
module rif_par_ctrl #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              stb_fall_i,
  input  logic              stb_low_i,
  input  logic              rnw_i,
  input  logic              dna_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic              cmd_we_o,
  output logic              cmd_re_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_wdata_o,
  output logic              drive_o
);
  logic [ADDR_W-1:0] addr_q;
  logic              act;

  assign act         = en_i && stb_fall_i;
  assign cmd_we_o    = act && !rnw_i && dna_i;
  assign cmd_re_o    = act && rnw_i;
  assign cmd_addr_o  = addr_q;
  assign cmd_wdata_o = bus_i;
  assign drive_o     = en_i && stb_low_i && rnw_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else if (act && !rnw_i && !dna_i) addr_q <= bus_i[ADDR_W-1:0];
  end
endmodule

// File: rtl/dual_mode_reg_if.sv
module dual_mode_reg_if
  import rif_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = RIF_ADDR_W,
  parameter int DATA_W      = RIF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sen_stb_i,
  input  logic              sck_rnw_i,
  input  logic              sdi_dna_i,
  input  logic              oe_ni,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  localparam logic [PIN_N-1:0] PIN_RST = PIN_N'(1) << PIN_CS;

  logic [PIN_N-1:0] pin_raw, pin_s;
  logic cs_prev_q, ck_prev_q;
  logic cs_rise, cs_fall, ck_rise;
  logic mode_vld_q;
  if_mode_e mode_q;
  logic ser_en, par_en;

  logic              s_we, s_re, s_sdo, s_busy;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_wdata;
  logic              p_we, p_re, p_drive;
  logic [ADDR_W-1:0] p_addr;
  logic [DATA_W-1:0] p_wdata;

  logic              we_q, re_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rd_q;

  always_comb begin
    pin_raw         = '0;
    pin_raw[PIN_CS] = sen_stb_i;
    pin_raw[PIN_CK] = sck_rnw_i;
    pin_raw[PIN_DI] = sdi_dna_i;
  end

  rif_pin_sync #(.W(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_raw),
    .q_o   (pin_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_prev_q <= 1'b1;
      ck_prev_q <= 1'b0;
    end else begin
      cs_prev_q <= pin_s[PIN_CS];
      ck_prev_q <= pin_s[PIN_CK];
    end
  end

  assign cs_rise = pin_s[PIN_CS] && !cs_prev_q;
  assign cs_fall = !pin_s[PIN_CS] && cs_prev_q;
  assign ck_rise = pin_s[PIN_CK] && !ck_prev_q;

  // interface type: raw pin level at the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_vld_q <= 1'b0;
      mode_q     <= MODE_SER;
    end else if (!mode_vld_q) begin
      mode_vld_q <= 1'b1;
      mode_q     <= if_mode_e'(sen_stb_i);
    end
  end

  assign ser_en = mode_vld_q && (mode_q == MODE_SER);
  assign par_en = mode_vld_q && (mode_q == MODE_PAR);

  rif_ser_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ser_en),
    .cs_rise_i  (cs_rise),
    .ck_rise_i  (ck_rise),
    .sdi_i      (pin_s[PIN_DI]),
    .ld_i       (re_q),
    .rdata_i    (reg_rdata_i),
    .cmd_we_o   (s_we),
    .cmd_re_o   (s_re),
    .cmd_addr_o (s_addr),
    .cmd_wdata_o(s_wdata),
    .sdo_o      (s_sdo),
    .busy_o     (s_busy)
  );

  rif_par_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_par (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (par_en),
    .stb_fall_i (cs_fall),
    .stb_low_i  (!pin_s[PIN_CS]),
    .rnw_i      (pin_s[PIN_CK]),
    .dna_i      (pin_s[PIN_DI]),
    .bus_i      (bus_i),
    .cmd_we_o   (p_we),
    .cmd_re_o   (p_re),
    .cmd_addr_o (p_addr),
    .cmd_wdata_o(p_wdata),
    .drive_o    (p_drive)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      re_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rd_q    <= '0;
    end else begin
      we_q <= s_we || p_we;
      re_q <= s_re || p_re;
      if (s_we || s_re)      addr_q <= s_addr;
      else if (p_we || p_re) addr_q <= p_addr;
      if (s_we)      wdata_q <= s_wdata;
      else if (p_we) wdata_q <= p_wdata;
      if (re_q) rd_q <= reg_rdata_i;
    end
  end

  assign reg_we_o    = we_q;
  assign reg_re_o    = re_q;
  assign reg_addr_o  = addr_q;
  assign reg_wdata_o = wdata_q;
  assign bus_o       = rd_q;
  assign bus_oe_o    = p_drive && !oe_ni;
  assign sdo_o       = s_sdo;
  assign sdo_oe_o    = s_busy && !oe_ni;
endmodule

// File: rtl/rif_checker.sv
module rif_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic oe_ni,
  input logic mode_vld_i,
  input logic mode_par_i,
  input logic we_i,
  input logic re_i,
  input logic bus_oe_i,
  input logic sdo_oe_i
);
  AST_IDLE_BEFORE_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_vld_i |-> (!we_i && !re_i && !bus_oe_i && !sdo_oe_i)); // R1
  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_vld_i |=> (mode_vld_i && $stable(mode_par_i))); // R2
  AST_OE_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> (!bus_oe_i && !sdo_oe_i)); // R8
  AST_SER_NO_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_vld_i && !mode_par_i) |-> !bus_oe_i); // R9
  AST_PAR_NO_SDO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_vld_i && mode_par_i) |-> !sdo_oe_i); // R9
  AST_WE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> !we_i); // R10
  AST_RE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i |=> !re_i); // R10
  AST_WE_RE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && re_i)); // R10
endmodule

bind dual_mode_reg_if rif_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .oe_ni     (oe_ni),
  .mode_vld_i(mode_vld_q),
  .mode_par_i(mode_q),
  .we_i      (reg_we_o),
  .re_i      (reg_re_o),
  .bus_oe_i  (bus_oe_o),
  .sdo_oe_i  (sdo_oe_o)
);

// File: tb/dual_mode_reg_if_test.sv
module dual_mode_reg_if_test;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sen_stb = 1'b0, sck_rnw = 1'b0, sdi_dna = 1'b0, oe_ni = 1'b0;
  logic [7:0] bus_in = '0;
  logic [7:0] bus_o, reg_wdata_o, reg_rdata_i;
  logic [5:0] reg_addr_o;
  logic bus_oe_o, sdo_o, sdo_oe_o, reg_we_o, reg_re_o;

  logic [7:0] mem [64];
  int total = 0, bad = 0, we_cnt = 0, sdo_par_hits = 0;
  bit par_phase = 0, done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dual_mode_reg_if uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sen_stb_i(sen_stb), .sck_rnw_i(sck_rnw),
    .sdi_dna_i(sdi_dna), .oe_ni(oe_ni), .bus_i(bus_in), .bus_o(bus_o),
    .bus_oe_o(bus_oe_o), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .reg_we_o(reg_we_o),
    .reg_re_o(reg_re_o), .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o),
    .reg_rdata_i(reg_rdata_i)
  );

  assign reg_rdata_i = mem[reg_addr_o];

  initial for (int i = 0; i < 64; i++) mem[i] = 8'h00;
  always @(posedge clk_i) if (reg_we_o) begin
    mem[reg_addr_o] <= reg_wdata_o;
    we_cnt <= we_cnt + 1;
  end
  always @(negedge clk_i) if (par_phase && sdo_oe_o) sdo_par_hits++;

  function automatic logic [7:0] sdat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction
  function automatic logic [7:0] pdat(input int a);
    return 8'(((a * 53 + 7) & 255) ^ 8'h5a);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_reset(input bit par);
    rst_ni = 1'b0; sen_stb = par; sck_rnw = 0; sdi_dna = 0; bus_in = '0; oe_ni = 0;
    wt(4);
    // R1: idle outputs while in reset
    chk(!reg_we_o && !reg_re_o && !bus_oe_o && !sdo_oe_o, "R1 reset idle",
        {reg_we_o, reg_re_o, bus_oe_o, sdo_oe_o}, 0);
    rst_ni = 1'b1;
    wt(6);
  endtask

  task automatic ser_bit(input logic b);
    sdi_dna = b; wt(HOLD);
    sck_rnw = 1; wt(HOLD);
    sck_rnw = 0;
  endtask

  task automatic ser_frame(input bit rd, input logic [5:0] a, input logic [7:0] d, input int nbits);
    logic [15:0] w;
    w = {rd, a, 1'b0, d};
    for (int i = 0; i < nbits; i++) ser_bit(i < 16 ? w[15-i] : 1'b0);
    wt(HOLD);
    sen_stb = 1; wt(8);
    sen_stb = 0; wt(4);
  endtask

  task automatic ser_read(input logic [5:0] a, output logic [7:0] v, output int oe_hits);
    ser_frame(1'b1, a, 8'h00, 16);
    v = '0; oe_hits = 0;
    for (int i = 0; i < 8; i++) begin
      v = {v[6:0], sdo_o};
      if (sdo_oe_o) oe_hits++;
      sck_rnw = 1; wt(HOLD);
      sck_rnw = 0; wt(HOLD);
    end
  endtask

  task automatic par_strobe(input bit rnw, input bit dna, input logic [7:0] d);
    sck_rnw = rnw; sdi_dna = dna; bus_in = d; wt(HOLD);
    sen_stb = 0; wt(6);
    sen_stb = 1; wt(6);
  endtask

  task automatic par_read(output logic [7:0] v, output bit oe_seen);
    sck_rnw = 1; sdi_dna = 1; wt(HOLD);
    sen_stb = 0; wt(8);
    v = bus_o; oe_seen = bus_oe_o;
    sen_stb = 1; wt(6);
    sck_rnw = 0;
  endtask

  initial begin
    logic [7:0] v;
    int hits, wc;
    bit oes;

    // ---------------- serial mode ----------------
    do_reset(1'b0);
    for (int a = 0; a < 64; a++) begin
      wc = we_cnt;
      ser_frame(1'b0, 6'(a), sdat(a), 16);
      chk(mem[a] == sdat(a) && we_cnt == wc + 1, "R3 serial write", mem[a], sdat(a));
    end
    wc = we_cnt;
    ser_frame(1'b0, 6'd5, 8'h00, 15);
    chk(mem[5] == sdat(5) && we_cnt == wc, "R4 short frame", mem[5], sdat(5));
    ser_frame(1'b0, 6'd6, 8'h00, 17);
    chk(mem[6] == sdat(6) && we_cnt == wc, "R4 long frame", mem[6], sdat(6));
    ser_frame(1'b0, 6'd7, 8'h00, 0);
    chk(mem[7] == sdat(7) && we_cnt == wc, "R4 empty frame", mem[7], sdat(7));
    for (int a = 0; a < 64; a++) begin
      ser_read(6'(a), v, hits);
      chk(v == sdat(a), "R5 serial read data", v, sdat(a));
      chk(hits == 8 && !sdo_oe_o, "R5 sdo_oe window", hits, 8);
    end
    oe_ni = 1;
    ser_read(6'd12, v, hits);
    chk(hits == 0, "R8 sdo suppressed", hits, 0);
    oe_ni = 0;
    // R9: parallel-style strobes in serial mode write nothing and never drive bus
    wc = we_cnt;
    sdi_dna = 1; sck_rnw = 1; bus_in = 8'hee; wt(HOLD);
    sen_stb = 1; wt(8);
    chk(!bus_oe_o, "R9 no bus in serial", bus_oe_o, 0);
    sen_stb = 0; wt(6); sck_rnw = 0; wt(6);
    chk(we_cnt == wc && mem[8'hee & 63] == sdat(8'hee & 63), "R9 strobe ignored", we_cnt, wc);
    chk(!bus_oe_o && !sdo_oe_o, "R9 idle drivers", {bus_oe_o, sdo_oe_o}, 0);

    // ---------------- parallel mode ----------------
    do_reset(1'b1);
    par_phase = 1;
    for (int a = 0; a < 64; a++) begin
      wc = we_cnt;
      par_strobe(0, 0, 8'(a));
      par_strobe(0, 1, pdat(a));
      chk(mem[a] == pdat(a) && we_cnt == wc + 1, "R6 R2 parallel write", mem[a], pdat(a));
    end
    par_strobe(0, 0, 8'd9);
    par_strobe(0, 1, 8'h11);
    par_strobe(0, 1, 8'h22);
    chk(mem[9] == 8'h22, "R6 address reuse", mem[9], 8'h22);
    chk(mem[10] == pdat(10), "R6 neighbour intact", mem[10], pdat(10));
    for (int a = 0; a < 64; a++) begin
      logic [7:0] e;
      e = (a == 9) ? 8'h22 : pdat(a);
      par_strobe(0, 0, 8'(a));
      par_read(v, oes);
      chk(v == e && oes, "R7 parallel read", v, e);
      chk(!bus_oe_o, "R7 bus released", bus_oe_o, 0);
    end
    oe_ni = 1;
    par_read(v, oes);
    chk(!oes, "R8 bus suppressed", oes, 0);
    oe_ni = 0;
    chk(sdo_par_hits == 0, "R9 no sdo in parallel", sdo_par_hits, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule